// File: doc/BRIEF.md
# Reference-Timed Clock Health Monitor

This block judges whether a monitored clock is healthy by measuring it against a separate reference clock, for example an on-chip oscillator that serves as a third, independent timebase. The monitored clock is brought into the reference domain through a synchroniser. Every change of level, rising or falling, is counted during a fixed window of reference cycles. At the end of each window the count is compared with a lower and an upper limit. A count under the lower limit means the clock has stopped or is far too slow. A count over the upper limit means it has jumped to a much higher frequency.

The verdict is published as a registered health flag and a two-bit fault code. Logic that chooses between redundant clocks can use these outputs. Because the flag falls on a single bad window but needs two good windows in a row before it rises, a failing oscillator drops out at once, while a recovering one has to prove itself first. For the edge sampling to be valid, the reference must run at no less than twice the monitored frequency.

Top module: `refmon`

## Requirements
- R1: `mon_clk` passes through a three-stage synchroniser clocked by `ref_clk`, and both rising and falling transitions are counted. A transition of `mon_clk` that occurs between reference edges t and t+1 is counted in the window that contains reference edge t+3.
- R2: A window is WINDOW_CYCLES reference edges long (default 256). Window k covers the edges kW to kW+W-1 after reset is released. `clk_ok` and `fault` take their new values at edge (k+1)W.
- R3: If the window count is below MIN_EDGES (default 32), which covers a stopped clock at either level, `fault` becomes 2'b01 and `clk_ok` is low.
- R4: If the window count is above MAX_EDGES (default 64), `fault` becomes 2'b10 and `clk_ok` is low.
- R5: The limits are inclusive. A count equal to MIN_EDGES or MAX_EDGES passes and gives `fault` 2'b00.
- R6: `clk_ok` falls after a single failing window, even when it was high before.
- R7: `clk_ok` rises only after two consecutive passing windows. It then stays high for as long as windows keep passing.
- R8: During reset and after it, `clk_ok` is 0 and `fault` is 2'b00 until the first window has been evaluated. Between evaluations both outputs hold their values.
- R9: The edge count never exceeds the window length, and `fault` never takes the code 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Independent reference clock |
| rst | input | 1 | Synchronous active-high reset, in the reference domain |
| mon_clk | input | 1 | Clock under observation, asynchronous to the reference |
| clk_ok | output | 1 | Registered health flag |
| fault | output | 2 | 00 ok, 01 too slow or stopped, 10 too fast |

## Verification
Two things can land on the same reference edge: the close of a window, and a synchronised transition arriving from the monitored clock. The stimulus spreads a set number of transitions across each window and keeps running across window boundaries. As a result, the final transitions of one window reach the counter on the very edge where that window closes, or on the first edges of the next window. The bench assigns every transition to a window using the three-edge latency given in R1 and then compares its own counts against the fault code. A closing edge that dropped a transition, or counted it twice, would therefore show up at the exact limits 32 and 64, and at 31 and 65.

// File: rtl/refmon_pkg.sv
package refmon_pkg;
  typedef enum logic [1:0] {
    MON_OK   = 2'b00,
    MON_SLOW = 2'b01,
    MON_FAST = 2'b10
  } mon_fault_e;
endpackage

// File: rtl/refmon_sync_edge.sv
module refmon_sync_edge #(
  parameter int STAGES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic mon_clk,
  output logic edge_seen
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[STAGES-2:0], mon_clk};
  end

  // any level change between the two oldest stages is one transition
  assign edge_seen = sr[STAGES-1] ^ sr[STAGES-2];
endmodule

// File: rtl/refmon_window.sv
module refmon_window #(
  parameter int WINDOW = 256,
  parameter int CW     = $clog2(WINDOW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          edge_in,
  output logic          win_done,
  output logic [CW-1:0] win_count
);
  localparam int TW = (WINDOW > 1) ? $clog2(WINDOW) : 1;
  localparam logic [TW-1:0] LAST = TW'(WINDOW - 1);

  logic [TW-1:0] timer;
  logic [CW-1:0] acc;
  logic          win_last;
  logic [CW-1:0] acc_next;

  assign win_last = (timer == LAST);
  assign acc_next = acc + CW'(edge_in);

  always_ff @(posedge clk) begin
    if (rst) begin
      timer     <= '0;
      acc       <= '0;
      win_done  <= 1'b0;
      win_count <= '0;
    end else begin
      win_done <= win_last;
      if (win_last) begin
        timer     <= '0;
        acc       <= '0;
        win_count <= acc_next;
      end else begin
        timer <= timer + 1'b1;
        acc   <= acc_next;
      end
    end
  end

  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (rst)
    acc <= CW'(WINDOW));
  assert_window_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    win_last |=> (timer == '0) && win_done);
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    win_done |=> !win_done);
endmodule

// File: rtl/refmon_verdict.sv
module refmon_verdict
  import refmon_pkg::*;
#(
  parameter int MIN_EDGES = 32,
  parameter int MAX_EDGES = 64,
  parameter int CW        = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          win_done,
  input  logic [CW-1:0] win_count,
  output logic          clk_ok,
  output logic [1:0]    fault
);
  localparam logic [CW-1:0] LO = CW'(MIN_EDGES);
  localparam logic [CW-1:0] HI = CW'(MAX_EDGES);

  mon_fault_e cls;
  logic [1:0] streak, streak_nxt;

  always_comb begin
    if (win_count < LO)      cls = MON_SLOW;
    else if (win_count > HI) cls = MON_FAST;
    else                     cls = MON_OK;
  end

  always_comb begin
    if (cls != MON_OK)      streak_nxt = 2'd0;
    else if (streak == 2'd2) streak_nxt = 2'd2;
    else                    streak_nxt = streak + 2'd1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      streak <= 2'd0;
      clk_ok <= 1'b0;
      fault  <= MON_OK;
    end else if (win_done) begin
      streak <= streak_nxt;
      clk_ok <= (streak_nxt == 2'd2);
      fault  <= cls;
    end
  end

  assert_code_legal_R9: assert property (@(posedge clk) disable iff (rst)
    fault != 2'b11);
  assert_fail_low_R6: assert property (@(posedge clk) disable iff (rst)
    (fault != 2'b00) |-> !clk_ok);
  assert_rise_after_pass_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_ok) |-> (fault == 2'b00) && (streak == 2'd2));
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(win_done) |-> $stable(clk_ok) && $stable(fault));
endmodule

// File: rtl/refmon.sv
module refmon #(
  parameter int WINDOW_CYCLES = 256,
  parameter int MIN_EDGES     = 32,
  parameter int MAX_EDGES     = 64,
  parameter int SYNC_STAGES   = 3
) (
  input  logic       ref_clk,
  input  logic       rst,
  input  logic       mon_clk,
  output logic       clk_ok,
  output logic [1:0] fault
);
  localparam int CW = $clog2(WINDOW_CYCLES + 1);

  logic          edge_seen;
  logic          win_done;
  logic [CW-1:0] win_count;

  refmon_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(ref_clk), .rst(rst), .mon_clk(mon_clk), .edge_seen(edge_seen)
  );

  refmon_window #(.WINDOW(WINDOW_CYCLES), .CW(CW)) u_window (
    .clk(ref_clk), .rst(rst), .edge_in(edge_seen),
    .win_done(win_done), .win_count(win_count)
  );

  refmon_verdict #(.MIN_EDGES(MIN_EDGES), .MAX_EDGES(MAX_EDGES), .CW(CW)) u_verdict (
    .clk(ref_clk), .rst(rst), .win_done(win_done), .win_count(win_count),
    .clk_ok(clk_ok), .fault(fault)
  );
endmodule

// File: tb/refmon_bench.sv
module refmon_bench;
  localparam int W    = 256;
  localparam int LO   = 32;
  localparam int HI   = 64;
  localparam int NWIN = 24;

  typedef struct {
    logic       ok;
    logic [1:0] fault;
    int         cnt;
    string      tag;
  } exp_t;

  logic       ref_clk = 1'b0;
  logic       rst = 1'b1;
  logic       mon_clk = 1'b0;
  logic       clk_ok;
  logic [1:0] fault;

  int   errors = 0, checks = 0;
  int   pe = -1;
  int   bucket [NWIN+2];
  int   streak = 0;
  bit   mon_done = 0;
  exp_t q[$];
  string cur_tag = "R2";

  always #10 ref_clk = ~ref_clk;

  refmon #(.WINDOW_CYCLES(W), .MIN_EDGES(LO), .MAX_EDGES(HI), .SYNC_STAGES(3)) u_refmon (
    .ref_clk(ref_clk), .rst(rst), .mon_clk(mon_clk), .clk_ok(clk_ok), .fault(fault)
  );

  always @(posedge ref_clk) begin
    if (rst) pe = -1;
    else     pe = pe + 1;
  end

  task automatic check(string tag, logic ok_e, logic [1:0] f_e);
    checks++;
    if (clk_ok !== ok_e || fault !== f_e) begin
      errors++;
      $display("FAIL %s: got ok=%b fault=%b, expected ok=%b fault=%b (edge %0d)",
               tag, clk_ok, fault, ok_e, f_e, pe);
    end
  endtask

  // close window k in the model and push its expected verdict (R1 latency)
  task automatic push_window(int k);
    exp_t e;
    logic prev_ok;
    prev_ok = (streak == 2);
    e.cnt = bucket[k];
    if (e.cnt < LO)      e.fault = 2'b01;
    else if (e.cnt > HI) e.fault = 2'b10;
    else                 e.fault = 2'b00;
    if (e.fault != 2'b00) streak = 0;
    else if (streak < 2)  streak++;
    e.ok = (streak == 2);
    if (e.cnt < LO)                   e.tag = "R3";
    else if (e.cnt > HI)              e.tag = "R4";
    else if (e.cnt == LO || e.cnt == HI) e.tag = "R5";
    else                              e.tag = cur_tag;
    if (prev_ok && !e.ok)        e.tag = {e.tag, "/R6"};
    if (!prev_ok && e.ok)        e.tag = {e.tag, "/R7"};
    if (!prev_ok && !e.ok && e.fault == 2'b00) e.tag = {e.tag, "/R7"};
    e.tag = $sformatf("%s win%0d cnt=%0d", e.tag, k, e.cnt);
    q.push_back(e);
  endtask

  // spread exactly n transitions over one window of reference edges
  task automatic drive_window(int n, string tag);
    cur_tag = tag;
    for (int j = 0; j < W; j++) begin
      @(posedge ref_clk);
      #1;
      if (((j + 1) * n) / W != (j * n) / W) begin
        mon_clk = ~mon_clk;
        if ((pe + 3) / W < NWIN + 2) bucket[(pe + 3) / W]++;
      end
      if ((pe + 3) % W == W - 1 && (pe + 3) / W < NWIN) push_window((pe + 3) / W);
    end
  endtask

  // driver
  initial begin
    for (int i = 0; i < NWIN + 2; i++) bucket[i] = 0;
    repeat (4) @(posedge ref_clk);
    #1 rst = 1'b0;
    drive_window(48, "R2");  drive_window(48, "R2");  drive_window(48, "R2");
    drive_window(0,  "R3");  drive_window(48, "R7");  drive_window(48, "R7");
    drive_window(128, "R4"); drive_window(48, "R7");  drive_window(48, "R7");
    drive_window(LO, "R5");  drive_window(LO, "R5");  drive_window(LO, "R5");
    drive_window(HI, "R5");  drive_window(HI, "R5");  drive_window(HI, "R5");
    drive_window(LO - 1, "R3"); drive_window(LO - 1, "R3");
    drive_window(HI + 1, "R4"); drive_window(HI + 1, "R4");
    drive_window(48, "R7");  drive_window(48, "R7");
    drive_window(W, "R1");   drive_window(1, "R1");  drive_window(0, "R1");
    drive_window(0, "R1");
  end

  // monitor / scoreboard
  initial begin
    exp_t e;
    logic       last_ok = 1'b0;
    logic [1:0] last_f  = 2'b00;
    @(negedge ref_clk);
    check("R8 in reset", 1'b0, 2'b00);
    wait (rst == 1'b0);
    for (int k = 0; k < NWIN; k++) begin
      while (pe != k * W + W / 2) @(negedge ref_clk);
      check($sformatf("R8 hold mid win%0d", k), last_ok, last_f);
      while (pe != k * W + W - 1) @(negedge ref_clk);
      check($sformatf("R2 no early update win%0d", k), last_ok, last_f);
      @(negedge ref_clk);
      if (q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2: no expected item for win%0d, got ok=%b fault=%b expected a queued verdict",
                 k, clk_ok, fault);
      end else begin
        e = q.pop_front();
        check(e.tag, e.ok, e.fault);
        last_ok = e.ok;
        last_f  = e.fault;
      end
    end
    mon_done = 1;
  end

  // completion and watchdog
  initial begin
    fork
      wait (mon_done);
      repeat (200000) @(posedge ref_clk);
    join_any
    if (!mon_done) begin
      checks++; errors++;
      $display("FAIL watchdog: got no completion, expected %0d windows", NWIN);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule